// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Bridge with Per-Access Width

This block connects a processor that drives a shared address/data bus to its external RAM and its memory-mapped I/O. While the address-latch strobe is high the shared bus carries the address. The bridge passes that address straight through, and it holds the address once the strobe falls, so that later data on the same wires does not disturb it. It decodes whether the held address falls inside a RAM window set by parameters, and it drives one of two active-low chip enables.

The bus width is chosen again for every access. RAM is an 8-bit device, so any access that hits the RAM window runs byte-wide on the low data lane. Everything else runs 16 bits wide. The width output is tied to the RAM enable, so a low level means 8-bit. Each byte lane has its own active-low write strobe, decoded from address bit 0 and the byte-high enable. A full-word access to RAM becomes two byte cycles, low byte first. The second cycle forces address bit 0 high. Read bytes from RAM come back on the low lane and are placed into the correct half of the 16-bit result.

A request is a read or write level held by the processor. The bridge runs one or two bus phases and then raises a one-cycle ready pulse. The assembled read data is valid during that pulse. The processor drops its request after it sees ready.

Top module: `mux_bus_bridge`

## Requirements
- R1: `mem_addr` equals `cpu_ad` while `cpu_ale` is high. After `cpu_ale` falls, `mem_addr` keeps the last address that was sampled, whatever `cpu_ad` does next.
- R2: During a bus phase, `ram_en_n` is low when the held address lies in [RAM_BASE, RAM_LAST], and `io_en_n` is low otherwise. Outside bus phases both are high, and they are never low together.
- R3: `bus_wide` is high (16-bit) exactly when `ram_en_n` is high. It is low (8-bit) during every RAM phase.
- R4: An access outside the RAM window takes one phase. `wr_lo_n` is low on a write when address bit 0 is 0. `wr_hi_n` is low on a write when `cpu_bhe_n` is 0. `mem_wdata` carries all 16 bits of `cpu_ad`. A read returns all 16 bits of `mem_rdata`.
- R5: A RAM access with address bit 0 = 0 and `cpu_bhe_n` = 0 takes two phases. The first phase uses the held address and the second uses the held address with bit 0 set. Any other RAM access takes one phase at the held address.
- R6: During a RAM write phase only `wr_lo_n` is driven low and `wr_hi_n` stays high. `mem_wdata[7:0]` carries the CPU high byte in a high-byte phase (second phase, or address bit 0 = 1) and the CPU low byte otherwise.
- R7: In a RAM read phase only `mem_rdata[7:0]` is used. A low-byte phase places it into result bits [7:0] and a high-byte phase places it into bits [15:8]. The other half of the result keeps its previous value.
- R8: `cpu_ready` is high for exactly one cycle, the cycle after the last phase. No chip enable is active in that cycle, and `cpu_rdata` then holds the assembled read data.
- R9: `rd_n` is low in every phase of a read and in no other cycle. A read drives neither write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ale | input | 1 | Address latch strobe, high during the address phase |
| cpu_ad | input | W | Shared address/data bus from the CPU |
| cpu_rd | input | 1 | Read request level |
| cpu_wr | input | 1 | Write request level |
| cpu_bhe_n | input | 1 | Active-low byte-high enable |
| cpu_rdata | output | W | Assembled read data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_addr | output | W | Latched address toward memory and I/O |
| mem_wdata | output | W | Write data toward memory and I/O |
| mem_rdata | input | W | Read data from memory and I/O |
| ram_en_n | output | 1 | Active-low RAM chip enable |
| io_en_n | output | 1 | Active-low enable for all other memory and I/O |
| bus_wide | output | 1 | Width select, low = 8-bit |
| rd_n | output | 1 | Active-low read strobe |
| wr_lo_n | output | 1 | Active-low low-byte write strobe |
| wr_hi_n | output | 1 | Active-low high-byte write strobe |

## Verification
The bench drives word, low-byte and high-byte accesses into both regions. It changes the bus value after the strobe falls, which shows up a latch that keeps following the bus. Two-phase RAM word accesses check that the second phase sets address bit 0 and takes the high byte; a bridge that skipped the split or reversed the order would show a wrong address or a swapped byte. The RAM model puts a constant on its upper lane and the bench runs single-byte reads one after another, so steering into the wrong half, or clearing the half that was not accessed, shows up as a data mismatch. Writes to RAM check that the high strobe stays idle, which catches a bridge that decoded the byte-high enable for the byte-wide device.

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge #(
  parameter int W = 16,
  parameter logic [W-1:0] RAM_BASE = 16'h8000,
  parameter logic [W-1:0] RAM_LAST = 16'hBFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_ale,
  input  logic [W-1:0] cpu_ad,
  input  logic         cpu_rd,
  input  logic         cpu_wr,
  input  logic         cpu_bhe_n,
  output logic [W-1:0] cpu_rdata,
  output logic         cpu_ready,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         ram_en_n,
  output logic         io_en_n,
  output logic         bus_wide,
  output logic         rd_n,
  output logic         wr_lo_n,
  output logic         wr_hi_n
);
  localparam int H = W / 2;

  typedef enum logic [1:0] {S_IDLE, S_PH1, S_PH2, S_FIN} state_t;

  state_t       st;
  logic [W-1:0] addr_q;
  logic         op_wr_q, bhe_n_q;

  logic in_ram, active, byte_hi, split;

  assign in_ram  = (addr_q >= RAM_BASE) && (addr_q <= RAM_LAST);
  assign active  = (st == S_PH1) || (st == S_PH2);
  assign byte_hi = (st == S_PH2) || (st == S_PH1 && addr_q[0]);
  assign split   = in_ram && !addr_q[0] && !bhe_n_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       addr_q <= '0;
    else if (cpu_ale) addr_q <= cpu_ad;

  assign mem_addr = cpu_ale ? cpu_ad : {addr_q[W-1:1], addr_q[0] | (st == S_PH2)};

  assign ram_en_n = !(active && in_ram);
  assign io_en_n  = !(active && !in_ram);
  assign bus_wide = ram_en_n;

  assign rd_n    = !(active && !op_wr_q);
  assign wr_lo_n = !(active && op_wr_q && (in_ram || !addr_q[0]));
  assign wr_hi_n = !(active && op_wr_q && !in_ram && !bhe_n_q);

  assign mem_wdata = in_ram ? {cpu_ad[W-1:H], byte_hi ? cpu_ad[W-1:H] : cpu_ad[H-1:0]}
                            : cpu_ad;

  assign cpu_ready = (st == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_wr_q   <= 1'b0;
      bhe_n_q   <= 1'b1;
      cpu_rdata <= '0;
    end else begin
      if (active && !op_wr_q) begin
        if (!in_ram)      cpu_rdata          <= mem_rdata;
        else if (byte_hi) cpu_rdata[W-1:H]   <= mem_rdata[H-1:0];
        else              cpu_rdata[H-1:0]   <= mem_rdata[H-1:0];
      end
      case (st)
        S_IDLE:
          if (!cpu_ale && (cpu_rd || cpu_wr)) begin
            st      <= S_PH1;
            op_wr_q <= cpu_wr;
            bhe_n_q <= cpu_bhe_n;
          end
        S_PH1:   st <= split ? S_PH2 : S_FIN;
        S_PH2:   st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module mux_bus_bridge_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cpu_ready,
  input logic [W-1:0] mem_addr,
  input logic         ram_en_n,
  input logic         io_en_n,
  input logic         bus_wide,
  input logic         rd_n,
  input logic         wr_lo_n,
  input logic         wr_hi_n
);
  // R2
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_en_n && !io_en_n));
  // R3
  width_follows_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en_n |-> !bus_wide);
  // R6
  ram_no_hi_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en_n |-> wr_hi_n);
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  // R8
  ready_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (ram_en_n && io_en_n && rd_n));
  // R9
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_lo_n && wr_hi_n));
  // R5
  ram_second_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_en_n && $past(!ram_en_n) && !$past(cpu_ready)) |-> mem_addr[0]);
endmodule

bind mux_bus_bridge mux_bus_bridge_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_addr(mem_addr),
  .ram_en_n(ram_en_n), .io_en_n(io_en_n), .bus_wide(bus_wide),
  .rd_n(rd_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n));

// File: tb/mux_bus_bridge_tb.sv
module mux_bus_bridge_tb_top;
  localparam int W = 16;
  localparam logic [W-1:0] RB = 16'h8000;
  localparam logic [W-1:0] RL = 16'hBFFF;

  logic clk = 0, rst_n = 0;
  logic cpu_ale = 0, cpu_rd = 0, cpu_wr = 0, cpu_bhe_n = 1;
  logic [W-1:0] cpu_ad = '0;
  logic [W-1:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
  logic cpu_ready, ram_en_n, io_en_n, bus_wide, rd_n, wr_lo_n, wr_hi_n;

  int checks = 0, errors = 0, cyc = 0;
  logic [W-1:0] exp_rdata = '0;

  always #10 clk = ~clk;

  mux_bus_bridge #(.W(W), .RAM_BASE(RB), .RAM_LAST(RL)) dut_i (.*);

  function automatic logic [W-1:0] pat(input logic [W-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C96;
  endfunction

  always_comb mem_rdata = !ram_en_n ? {8'hEE, pat(mem_addr)[7:0]} : pat(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [W-1:0] a, input bit wr, input bit bhe_n, input logic [W-1:0] wd);
    bit ram, two;
    int np;
    logic [W-1:0] ea;
    bit bhi;
    ram = (a >= RB) && (a <= RL);
    two = ram && !a[0] && !bhe_n;
    np  = two ? 2 : 1;
    @(negedge clk); cpu_ale = 1; cpu_ad = a; #1;
    chk(mem_addr == a, "R1 transparent", mem_addr, a);
    @(negedge clk); cpu_ale = 0; cpu_ad = wr ? wd : 16'h5A5A;
    cpu_rd = !wr; cpu_wr = wr; cpu_bhe_n = bhe_n; #1;
    chk(mem_addr == a, "R1 held", mem_addr, a);
    chk(ram_en_n && io_en_n, "R2 idle", {ram_en_n, io_en_n}, 2'b11);
    for (int p = 0; p < np; p++) begin
      @(negedge clk); #1;
      ea  = (p == 1) ? (a | 16'h1) : a;
      bhi = ram && (p == 1 || a[0]);
      chk(mem_addr == ea, "R5 phase address", mem_addr, ea);
      chk(ram_en_n == !ram && io_en_n == ram, "R2 enables", {ram_en_n, io_en_n}, {!ram, ram});
      chk(bus_wide == !ram, "R3 width", bus_wide, !ram);
      chk(rd_n == wr, "R9 read strobe", rd_n, wr);
      chk(wr_lo_n == !(wr && (ram || !a[0])), ram ? "R6 low strobe" : "R4 low strobe", wr_lo_n, !(wr && (ram || !a[0])));
      chk(wr_hi_n == !(wr && !ram && !bhe_n), ram ? "R6 high strobe" : "R4 high strobe", wr_hi_n, !(wr && !ram && !bhe_n));
      chk(!cpu_ready, "R8 no early ready", cpu_ready, 0);
      if (wr && ram)
        chk(mem_wdata[7:0] == (bhi ? wd[15:8] : wd[7:0]), "R6 lane data", mem_wdata[7:0], bhi ? wd[15:8] : wd[7:0]);
      if (wr && !ram)
        chk(mem_wdata == wd, "R4 word data", mem_wdata, wd);
      if (!wr) begin
        if (!ram) exp_rdata = pat(ea);
        else if (bhi) exp_rdata[15:8] = pat(ea)[7:0];
        else exp_rdata[7:0] = pat(ea)[7:0];
      end
    end
    @(negedge clk); #1;
    chk(cpu_ready, "R8 ready", cpu_ready, 1);
    chk(ram_en_n && io_en_n, "R8 bus idle at ready", {ram_en_n, io_en_n}, 2'b11);
    if (!wr) chk(cpu_rdata == exp_rdata, ram ? "R7 steered read" : "R4 word read", cpu_rdata, exp_rdata);
    cpu_rd = 0; cpu_wr = 0;
    @(negedge clk); #1;
    chk(!cpu_ready, "R8 single pulse", cpu_ready, 0);
    chk(rd_n && wr_lo_n && wr_hi_n, "R9 idle strobes", {rd_n, wr_lo_n, wr_hi_n}, 3'b111);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL R8 watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    #1;
    chk(!cpu_ready && ram_en_n && io_en_n && rd_n && wr_lo_n && wr_hi_n, "R2 reset outputs",
        {cpu_ready, ram_en_n, io_en_n, rd_n, wr_lo_n, wr_hi_n}, 6'b011111);
    chk(cpu_rdata == 0, "R8 reset data", cpu_rdata, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    access(16'h1234, 0, 0, 0);
    access(16'h2000, 1, 0, 16'hBEEF);
    access(16'h2001, 1, 0, 16'hCAFE);
    access(16'h2002, 1, 1, 16'h1357);
    access(16'h4567, 0, 0, 0);
    access(16'h8010, 0, 0, 0);
    access(16'h8020, 1, 0, 16'hA1B2);
    access(16'h8031, 0, 0, 0);
    access(16'h8044, 0, 1, 0);
    access(16'h8055, 1, 0, 16'h77C4);
    access(16'h8066, 1, 1, 16'h9E3D);
    access(RB, 0, 0, 0);
    access(RL, 0, 0, 0);
    access(RL + 16'h1, 0, 0, 0);
    access(RB - 16'h1, 1, 0, 16'h0F0F);
    access(16'hFFFE, 0, 0, 0);
    finish_run();
  end
endmodule